// File: doc/BRIEF.md
# Relocatable Register-Window Base Decoder

This block places the whole 4-Kbyte bank of on-chip peripheral registers at a location chosen by software. It keeps one base register that holds the upper twenty address bits of the bank and a valid flag. The bank can therefore begin on any 4-Kbyte boundary. The block watches a simple CPU bus made of a strobe, an address, a function code, a read/write line, an access size and write data. On each strobed access it decides, in the same cycle, whether the address falls inside the bank. On a hit it passes the low twelve address bits on as the register offset.

The base register itself can be reached in only one way: a CPU-space access (function code 0x7) to the fixed address 0x0003FF00. The same address in any other space is an ordinary address and may fall inside the bank. A long-size write through that path loads the base and marks it valid in one clock. A read through it returns the stored base with the valid flag in bit 0. Until the first such write, the bank decodes nothing.

Top module: `win_reloc_decoder`

## Requirements
- R1: The base register is selected (`cfg_sel`=1) only when `bus_strobe`=1, `bus_fc`=4'h7 and `bus_addr`=32'h0003FF00. For any other function code at that address, `cfg_sel`=0 and `cfg_rdata`=0.
- R2: After reset the valid flag is clear. No access raises `win_hit` and a base read returns 32'h0.
- R3: A selected write (`bus_rw`=0) with `bus_size`=2'b10 (long) stores `bus_wdata[31:12]` as the base and sets the valid flag at that clock edge. From the next cycle a selected read (`bus_rw`=1) returns {base, 11'b0, 1'b1}.
- R4: A selected write with size byte (2'b00), word (2'b01) or reserved (2'b11) leaves the base and the valid flag unchanged. A write attempted with a function code other than 0x7 also leaves them unchanged.
- R5: `win_hit`=1 exactly when `bus_strobe`=1, the valid flag is set, `bus_fc`≠4'h7 and `bus_addr[31:12]` equals the base. The addresses base+0x000 and base+0xFFF hit; base−1 and base+0x1000 do not.
- R6: While `win_hit`=1, `win_offset` equals `bus_addr[11:0]`. Otherwise `win_offset` is 0.
- R7: An access that selects the base register never raises `win_hit`, even when the base is 0x0003F000.
- R8: `win_hit`, `win_offset`, `cfg_sel` and `cfg_rdata` are combinational from the bus inputs of the same cycle. With `bus_strobe`=0 they are all 0 and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | Access in progress this cycle |
| bus_addr | input | 32 | Byte address |
| bus_fc | input | 4 | Function code; 4'h7 is CPU space |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_size | input | 2 | 00 byte, 01 word, 10 long, 11 reserved |
| bus_wdata | input | 32 | Write data |
| win_hit | output | 1 | Address falls inside the register bank |
| win_offset | output | 12 | Offset within the bank on a hit |
| cfg_sel | output | 1 | Base register selected |
| cfg_rdata | output | 32 | Base register read data on a selected read |

## Verification
The hardest case to reach is a base that covers the register's own address 0x0003FF00. In that case the CPU-space path and the bank compare disagree about the same address, and the function code alone must decide between them. The stimulus first relocates the bank to 0x0003F000 with a long CPU-space write. It then presents 0x0003FF00 under CPU space and under a data-space code in back-to-back cycles. The first must select only the base register. The second must hit the bank at offset 0xF00.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } bus_size_e;
endpackage

// File: rtl/win_base_reg.sv
module win_base_reg #(
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_base,
  output logic [BASE_W-1:0] base_q,
  output logic              valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else if (wr_en) begin
      base_q  <= wr_base;
      valid_q <= 1'b1;
    end
  end

  // R3: a load shows up one clock after the write strobe
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q && base_q == $past(wr_base)));
  // R4: without a write strobe the register holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(valid_q)));
endmodule

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int              ADDR_W = 32,
  parameter int              OFS_W  = 12,
  parameter int              FC_W   = 4,
  parameter logic [FC_W-1:0] CPU_FC = 4'h7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [FC_W-1:0]         fc,
  input  logic [ADDR_W-OFS_W-1:0] base,
  input  logic                    base_valid,
  output logic                    hit,
  output logic [OFS_W-1:0]        offset
);
  localparam int BASE_W = ADDR_W - OFS_W;

  function automatic logic page_match(input logic [ADDR_W-1:0] a,
                                      input logic [BASE_W-1:0] b);
    return a[ADDR_W-1:OFS_W] == b;
  endfunction

  logic space_ok;
  assign space_ok = (fc != CPU_FC);
  assign hit      = strobe && base_valid && space_ok && page_match(addr, base);
  assign offset   = hit ? addr[OFS_W-1:0] : '0;

  // R2: nothing decodes before a base has been written
  p_no_hit_unset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !base_valid |-> !hit);
  // R6: offset is quiet outside a hit
  p_offset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (offset == '0));
endmodule

// File: rtl/win_reloc_decoder.sv
module win_reloc_decoder #(
  parameter int                ADDR_W   = 32,
  parameter int                OFS_W    = 12,
  parameter int                FC_W     = 4,
  parameter logic [FC_W-1:0]   CPU_FC   = 4'h7,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0003FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FC_W-1:0]   bus_fc,
  input  logic              bus_rw,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_wdata,
  output logic              win_hit,
  output logic [OFS_W-1:0]  win_offset,
  output logic              cfg_sel,
  output logic [ADDR_W-1:0] cfg_rdata
);
  import win_pkg::*;
  localparam int BASE_W = ADDR_W - OFS_W;

  function automatic logic [ADDR_W-1:0] pack_readback(input logic [BASE_W-1:0] b,
                                                      input logic v);
    return {b, {(OFS_W-1){1'b0}}, v};
  endfunction

  logic              cfg_wr;
  logic [BASE_W-1:0] base_q;
  logic              valid_q;

  assign cfg_sel   = bus_strobe && (bus_fc == CPU_FC) && (bus_addr == CFG_ADDR);
  assign cfg_wr    = cfg_sel && !bus_rw && (bus_size == SZ_LONG);
  assign cfg_rdata = (cfg_sel && bus_rw) ? pack_readback(base_q, valid_q) : '0;

  win_base_reg #(.BASE_W(BASE_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_base (bus_wdata[ADDR_W-1:OFS_W]),
    .base_q  (base_q),
    .valid_q (valid_q)
  );

  win_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .FC_W(FC_W), .CPU_FC(CPU_FC)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (bus_strobe),
    .addr       (bus_addr),
    .fc         (bus_fc),
    .base       (base_q),
    .base_valid (valid_q),
    .hit        (win_hit),
    .offset     (win_offset)
  );

  // R7: the base register path and the bank never claim the same access
  p_cfg_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> !win_hit);
  // R8: an idle bus produces no outputs
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> (!win_hit && !cfg_sel && cfg_rdata == '0));
  // R1: a selected register always carries CPU space
  p_cfg_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (bus_fc == CPU_FC));
endmodule

// File: tb/tb_win_reloc_decoder.sv
module tb_win_reloc_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_fc = '0;
  logic        bus_rw = 1'b1;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic        win_hit;
  logic [11:0] win_offset;
  logic        cfg_sel;
  logic [31:0] cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] REG_A = 32'h0003FF00;

  always #2 clk = ~clk;

  win_reloc_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_rw(bus_rw), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .win_hit(win_hit), .win_offset(win_offset), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic stb, input logic [31:0] a, input logic [3:0] fc,
                         input logic rw, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    bus_strobe = stb; bus_addr = a; bus_fc = fc; bus_rw = rw; bus_size = sz; bus_wdata = wd;
    #1;
  endtask

  task automatic idle();
    present(1'b0, 32'h0, 4'h0, 1'b1, 2'b10, 32'h0);
  endtask

  task automatic write_cfg(input logic [3:0] fc, input logic [1:0] sz, input logic [31:0] wd);
    present(1'b1, REG_A, fc, 1'b0, sz, wd);
    idle();
  endtask

  task automatic expect_read(input string req, input logic [31:0] exp);
    present(1'b1, REG_A, 4'h7, 1'b1, 2'b10, 32'h0);
    check(req, {31'b0, cfg_sel}, 32'h1);
    check(req, cfg_rdata, exp);
    check(req, {31'b0, win_hit}, 32'h0);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [3:0] fc,
                       input logic exp_hit, input logic [11:0] exp_ofs);
    present(1'b1, a, fc, 1'b1, 2'b10, 32'h0);
    check(req, {31'b0, win_hit}, {31'b0, exp_hit});
    check(req, {20'b0, win_offset}, {20'b0, exp_ofs});
  endtask

  task automatic t_reset();
    expect_read("R2", 32'h0);
    probe("R2", 32'h00000000, 4'h5, 1'b0, 12'h0);
    probe("R2", 32'h12345000, 4'h1, 1'b0, 12'h0);
  endtask

  task automatic t_load_and_bounds();
    write_cfg(4'h7, 2'b10, 32'h12345ABC);
    expect_read("R3", 32'h12345001);
    probe("R5", 32'h12345000, 4'h5, 1'b1, 12'h000);
    probe("R5", 32'h12345FFF, 4'h1, 1'b1, 12'hFFF);
    probe("R6", 32'h12345A5C, 4'h2, 1'b1, 12'hA5C);
    probe("R5", 32'h12344FFF, 4'h5, 1'b0, 12'h0);
    probe("R5", 32'h12346000, 4'h5, 1'b0, 12'h0);
    probe("R5", 32'h12345010, 4'h7, 1'b0, 12'h0);
  endtask

  task automatic t_ignored_writes();
    write_cfg(4'h5, 2'b10, 32'hAAAAA000);
    expect_read("R4", 32'h12345001);
    write_cfg(4'h7, 2'b01, 32'hBBBBB000);
    write_cfg(4'h7, 2'b00, 32'hCCCCC000);
    write_cfg(4'h7, 2'b11, 32'hDDDDD000);
    expect_read("R4", 32'h12345001);
    present(1'b1, REG_A, 4'h5, 1'b1, 2'b10, 32'h0);
    check("R1", {31'b0, cfg_sel}, 32'h0);
    check("R1", cfg_rdata, 32'h0);
    present(1'b1, REG_A + 32'h4, 4'h7, 1'b1, 2'b10, 32'h0);
    check("R1", {31'b0, cfg_sel}, 32'h0);
  endtask

  task automatic t_overlap();
    write_cfg(4'h7, 2'b10, 32'h0003F000);
    expect_read("R7", 32'h0003F001);
    probe("R7", REG_A, 4'h5, 1'b1, 12'hF00);
    present(1'b1, REG_A, 4'h7, 1'b0, 2'b10, 32'h0003F000);
    check("R7", {31'b0, win_hit}, 32'h0);
    check("R7", {31'b0, cfg_sel}, 32'h1);
    idle();
  endtask

  task automatic t_top_and_idle();
    write_cfg(4'h7, 2'b10, 32'hFFFFF000);
    expect_read("R3", 32'hFFFFF001);
    probe("R5", 32'hFFFFFFFF, 4'h6, 1'b1, 12'hFFF);
    probe("R5", 32'hFFFFEFFF, 4'h6, 1'b0, 12'h0);
    present(1'b0, 32'hFFFFF123, 4'h5, 1'b1, 2'b10, 32'h0);
    check("R8", {31'b0, win_hit}, 32'h0);
    check("R8", {20'b0, win_offset}, 32'h0);
    present(1'b0, REG_A, 4'h7, 1'b0, 2'b10, 32'h55555000);
    check("R8", {31'b0, cfg_sel}, 32'h0);
    idle();
    expect_read("R8", 32'hFFFFF001);
    probe("R8", 32'hFFFFF123, 4'h5, 1'b1, 12'h123);
    probe("R8", 32'h00001123, 4'h5, 1'b0, 12'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_and_bounds();
    t_ignored_writes();
    t_overlap();
    t_top_and_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule